// File: doc/BRIEF.md
# Flash status and suspend tracker

This block keeps the status and control bits of a serial flash device and decides, for every decoded command, whether that command may proceed. A command front end hands it one opcode per cycle, plus a data word for status writes. The block answers one cycle later with accept or reject. For a status read it also returns the requested status byte. It publishes the live 16-bit status word and three level signals: may a read start now, may a program or erase start now, and may the security area be modified now.

A program, erase or status write that is accepted starts an internal cycle counter. The counter stands in for the physical operation time. While the counter runs, the busy bit is set, and nearly every other command is turned away. A program or erase in progress can be paused. While it is paused, the busy bit reads 0, reads and write-enable changes are served again, and the counter keeps its remaining count until a resume command arrives. The non-volatile bits are plain registers.

Top module: `flash_status_tracker`

## Requirements
- R1: After reset, `status_o` is 0, `accept_o` and `reject_o` are 0, and no operation is running.
- R2: An accepted 06h sets the write-enable bit (`status_o[1]`). An accepted 04h clears it.
- R3: A status read returns its byte on `rd_data_o` in the cycle after the command, and that byte is taken from the state before the command.
  - 05h returns the low byte, bit 7 down to bit 0: protect-method bit, five protection-range bits, write-enable, busy.
  - 35h returns the high byte: bit 7 is the suspend flag, bit 6 is the complement bit, bit 2 is the security lock. All other bits of the high byte are 0.
- R4: While write-enable is 0, every modifying command is rejected and changes no state. The modifying commands are:
  - status write 01h;
  - page program 02h;
  - erases 20h, 52h, D8h, C7h and 60h;
  - security program 42h and security erase 44h.
- R5: An accepted modifying command holds busy at 1 for exactly a set number of cycles, then busy and write-enable clear in the same cycle. The counts are:
  - PROG_CYC for 02h and 42h;
  - SECT_CYC for 20h, 52h, D8h and 44h;
  - CHIP_CYC for C7h and 60h;
  - WRSR_CYC for 01h.
- R6: While busy is 1, only 05h, 35h and 75h can be accepted. All other opcodes are rejected.
- R7: Suspend 75h is handled as follows.
  - During a program or erase, 75h sets the suspend flag (`status_o[15]`), busy reads 0, and the counter holds.
  - With no program or erase running, or during a status write, 75h is rejected and the flag stays 0.
- R8: While suspended, every modifying command from R4 is rejected, even with write-enable set. Reads (03h, 0Bh and the other read opcodes) and 06h/04h are accepted.
- R9: Resume 7Ah clears the suspend flag, and the paused operation finishes after exactly the cycles it had left. 7Ah is rejected when not suspended.
- R10: An accepted 01h loads the following bits at once:
  - `cmd_wdata_i[7:2]` into status bits 7..2;
  - `cmd_wdata_i[14]` into the complement bit.
  - `cmd_wdata_i[10]` is ORed into the security lock, so a lock that is set never clears.
- R11: With the security lock set, 42h and 44h are rejected even with write-enable set, and they leave write-enable unchanged.
- R12: Every `cmd_valid_i` cycle is followed by exactly one of `accept_o` or `reject_o`. Both are 0 after a cycle with no command. An unknown opcode is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 8 | Command opcode |
| cmd_wdata_i | input | 16 | Status word for 01h |
| accept_o | output | 1 | Previous-cycle command accepted |
| reject_o | output | 1 | Previous-cycle command refused |
| rd_data_o | output | 8 | Status byte for the last accepted status read |
| status_o | output | 16 | Live status word |
| allow_read_o | output | 1 | A read may start now |
| allow_modify_o | output | 1 | A program, erase or status write may start now |
| allow_secure_o | output | 1 | A security-area program or erase may start now |

## Verification
The hardest case to reach is a suspend that lands partway through an erase, followed by a resume many cycles later. The remaining count is invisible at the ports and only shows up as the length of busy after resume. The stimulus first lets a sector erase count down for a known number of idle cycles, then issues 75h. It then runs a batch of refused and allowed commands and a long idle gap while the erase is paused. Finally it issues 7Ah and measures busy cycle by cycle against the configured erase length minus the cycles already spent.

// File: rtl/fst_pkg.sv
package fst_pkg;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_WREN,
    CLS_WRDI,
    CLS_RD_LO,
    CLS_RD_HI,
    CLS_WRSR,
    CLS_PROG,
    CLS_ERASE,
    CLS_SEC_MOD,
    CLS_SUSPEND,
    CLS_RESUME,
    CLS_READ
  } cmd_cls_e;

  typedef enum logic [1:0] {
    OPK_PROG,
    OPK_SECT,
    OPK_CHIP,
    OPK_WRSR
  } op_kind_e;

  localparam logic [7:0] OPC_WREN     = 8'h06;
  localparam logic [7:0] OPC_WRDI     = 8'h04;
  localparam logic [7:0] OPC_RD_LO    = 8'h05;
  localparam logic [7:0] OPC_RD_HI    = 8'h35;
  localparam logic [7:0] OPC_WRSR     = 8'h01;
  localparam logic [7:0] OPC_PROG     = 8'h02;
  localparam logic [7:0] OPC_SE4K     = 8'h20;
  localparam logic [7:0] OPC_BE32     = 8'h52;
  localparam logic [7:0] OPC_BE64     = 8'hD8;
  localparam logic [7:0] OPC_CE_A     = 8'hC7;
  localparam logic [7:0] OPC_CE_B     = 8'h60;
  localparam logic [7:0] OPC_SEC_PROG = 8'h42;
  localparam logic [7:0] OPC_SEC_ERA  = 8'h44;
  localparam logic [7:0] OPC_SUSPEND  = 8'h75;
  localparam logic [7:0] OPC_RESUME   = 8'h7A;

  // status word bit positions
  localparam int unsigned ST_WIP = 0;
  localparam int unsigned ST_WEL = 1;
  localparam int unsigned ST_LB  = 10;
  localparam int unsigned ST_CMP = 14;
  localparam int unsigned ST_SUS = 15;

endpackage

// File: rtl/fst_cmd_decode.sv
module fst_cmd_decode
  import fst_pkg::*;
(
  input  logic [7:0] op_i,
  output cmd_cls_e   cls_o,
  output op_kind_e   kind_o
);

  always_comb begin
    cls_o  = CLS_NONE;
    kind_o = OPK_PROG;
    case (op_i)
      OPC_WREN:     cls_o = CLS_WREN;
      OPC_WRDI:     cls_o = CLS_WRDI;
      OPC_RD_LO:    cls_o = CLS_RD_LO;
      OPC_RD_HI:    cls_o = CLS_RD_HI;
      OPC_WRSR: begin
        cls_o  = CLS_WRSR;
        kind_o = OPK_WRSR;
      end
      OPC_PROG: begin
        cls_o  = CLS_PROG;
        kind_o = OPK_PROG;
      end
      OPC_SE4K, OPC_BE32, OPC_BE64: begin
        cls_o  = CLS_ERASE;
        kind_o = OPK_SECT;
      end
      OPC_CE_A, OPC_CE_B: begin
        cls_o  = CLS_ERASE;
        kind_o = OPK_CHIP;
      end
      OPC_SEC_PROG: begin
        cls_o  = CLS_SEC_MOD;
        kind_o = OPK_PROG;
      end
      OPC_SEC_ERA: begin
        cls_o  = CLS_SEC_MOD;
        kind_o = OPK_SECT;
      end
      OPC_SUSPEND:  cls_o = CLS_SUSPEND;
      OPC_RESUME:   cls_o = CLS_RESUME;
      8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'hE7, 8'h48, 8'h9F, 8'h90, 8'hAB:
                    cls_o = CLS_READ;
      default:      cls_o = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/fst_op_timer.sv
module fst_op_timer
  import fst_pkg::*;
#(
  parameter int unsigned PROG_CYC = 6,
  parameter int unsigned SECT_CYC = 12,
  parameter int unsigned CHIP_CYC = 20,
  parameter int unsigned WRSR_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  op_kind_e kind_i,
  input  logic     hold_i,
  output logic     active_o,
  output logic     done_o,
  output op_kind_e kind_o
);

  localparam int unsigned MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_CD  = (CHIP_CYC > WRSR_CYC) ? CHIP_CYC : WRSR_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             active_q;
  op_kind_e         kind_q;

  always_comb begin
    case (kind_i)
      OPK_PROG: load_val = CNT_W'(PROG_CYC);
      OPK_SECT: load_val = CNT_W'(SECT_CYC);
      OPK_CHIP: load_val = CNT_W'(CHIP_CYC);
      default:  load_val = CNT_W'(WRSR_CYC);
    endcase
  end

  assign done_o = active_q && !hold_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      kind_q   <= OPK_PROG;
    end else if (start_i) begin
      cnt_q    <= load_val;
      active_q <= 1'b1;
      kind_q   <= kind_i;
    end else if (active_q && !hold_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;

endmodule

// File: rtl/fst_status_regs.sv
module fst_status_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       wr_en_i,
  input  logic [5:0] wr_prot_i,
  input  logic       wr_cmp_i,
  input  logic       wr_lock_i,
  input  logic       set_sus_i,
  input  logic       clr_sus_i,
  output logic       wel_o,
  output logic       sus_o,
  output logic [5:0] prot_o,
  output logic       cmp_o,
  output logic       lock_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o <= 1'b0;
    end else if (clr_wel_i) begin
      wel_o <= 1'b0;
    end else if (set_wel_i) begin
      wel_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sus_o <= 1'b0;
    end else if (set_sus_i) begin
      sus_o <= 1'b1;
    end else if (clr_sus_i) begin
      sus_o <= 1'b0;
    end
  end

  // lock bit only ever rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_o <= '0;
      cmp_o  <= 1'b0;
      lock_o <= 1'b0;
    end else if (wr_en_i) begin
      prot_o <= wr_prot_i;
      cmp_o  <= wr_cmp_i;
      lock_o <= lock_o | wr_lock_i;
    end
  end

endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
  import fst_pkg::*;
#(
  parameter int unsigned PROG_CYC = 6,
  parameter int unsigned SECT_CYC = 12,
  parameter int unsigned CHIP_CYC = 20,
  parameter int unsigned WRSR_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [7:0]  cmd_op_i,
  input  logic [15:0] cmd_wdata_i,
  output logic        accept_o,
  output logic        reject_o,
  output logic [7:0]  rd_data_o,
  output logic [15:0] status_o,
  output logic        allow_read_o,
  output logic        allow_modify_o,
  output logic        allow_secure_o
);

  cmd_cls_e cls;
  op_kind_e dec_kind;
  op_kind_e run_kind;
  logic     active, done, hold;
  logic     wel, sus, cmp, lock;
  logic [5:0] prot;
  logic     busy, allow, acc;
  logic     start, set_sus, clr_sus;
  logic     unused_wdata;

  assign unused_wdata = ^{cmd_wdata_i[15], cmd_wdata_i[13:11], cmd_wdata_i[9:8], cmd_wdata_i[1:0]};

  fst_cmd_decode u_dec (
    .op_i   (cmd_op_i),
    .cls_o  (cls),
    .kind_o (dec_kind)
  );

  assign busy           = active && !sus;
  assign allow_read_o   = !busy;
  assign allow_modify_o = !active && wel;
  assign allow_secure_o = !active && wel && !lock;

  always_comb begin
    case (cls)
      CLS_WREN, CLS_WRDI, CLS_READ:  allow = !busy;
      CLS_RD_LO, CLS_RD_HI:          allow = 1'b1;
      CLS_WRSR, CLS_PROG, CLS_ERASE: allow = allow_modify_o;
      CLS_SEC_MOD:                   allow = allow_secure_o;
      CLS_SUSPEND:                   allow = busy && (run_kind != OPK_WRSR);
      CLS_RESUME:                    allow = sus;
      default:                       allow = 1'b0;
    endcase
  end

  assign acc     = cmd_valid_i && allow;
  assign start   = acc && (cls inside {CLS_WRSR, CLS_PROG, CLS_ERASE, CLS_SEC_MOD});
  assign set_sus = acc && (cls == CLS_SUSPEND);
  assign clr_sus = acc && (cls == CLS_RESUME);
  assign hold    = sus || set_sus;

  fst_op_timer #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC),
    .WRSR_CYC (WRSR_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .kind_i   (dec_kind),
    .hold_i   (hold),
    .active_o (active),
    .done_o   (done),
    .kind_o   (run_kind)
  );

  fst_status_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_wel_i (acc && (cls == CLS_WREN)),
    .clr_wel_i (done || (acc && (cls == CLS_WRDI))),
    .wr_en_i   (acc && (cls == CLS_WRSR)),
    .wr_prot_i (cmd_wdata_i[7:2]),
    .wr_cmp_i  (cmd_wdata_i[ST_CMP]),
    .wr_lock_i (cmd_wdata_i[ST_LB]),
    .set_sus_i (set_sus),
    .clr_sus_i (clr_sus),
    .wel_o     (wel),
    .sus_o     (sus),
    .prot_o    (prot),
    .cmp_o     (cmp),
    .lock_o    (lock)
  );

  assign status_o = {sus, cmp, 3'b000, lock, 2'b00, prot, wel, busy};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o  <= 1'b0;
      reject_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      accept_o <= acc;
      reject_o <= cmd_valid_i && !allow;
      if (acc && cls == CLS_RD_LO) rd_data_o <= status_o[7:0];
      if (acc && cls == CLS_RD_HI) rd_data_o <= status_o[15:8];
    end
  end

endmodule

// File: rtl/flash_status_tracker_chk.sv
module flash_status_tracker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [7:0]  cmd_op_i,
  input logic        accept_o,
  input logic        reject_o,
  input logic [15:0] status_o
);

  a_r12_one_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (accept_o ^ reject_o));

  a_r12_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !(accept_o || reject_o));

  a_r7_not_busy_when_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15] |-> !status_o[0]);

  a_r5_wel_drops_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(status_o[0]) && !status_o[15]) |-> !status_o[1]);

  a_r4_modify_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !status_o[1] &&
     (cmd_op_i == 8'h01 || cmd_op_i == 8'h02 || cmd_op_i == 8'h20 ||
      cmd_op_i == 8'hD8 || cmd_op_i == 8'hC7 || cmd_op_i == 8'h44)) |=> reject_o);

  a_r8_no_program_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && status_o[15] && cmd_op_i == 8'h02) |=> reject_o);

  a_r9_resume_needs_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !status_o[15] && cmd_op_i == 8'h7A) |=> reject_o);

  a_r10_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[10] |=> status_o[10]);

endmodule

bind flash_status_tracker flash_status_tracker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .accept_o    (accept_o),
  .reject_o    (reject_o),
  .status_o    (status_o)
);

// File: tb/flash_status_tracker_tb.sv
`timescale 1ns/1ps
module flash_status_tracker_tb;

  localparam int unsigned PROG_CYC = 6;
  localparam int unsigned SECT_CYC = 12;
  localparam int unsigned CHIP_CYC = 20;
  localparam int unsigned WRSR_CYC = 4;

  typedef struct {
    bit         acc;
    bit         chk_rd;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_op_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic        accept_o, reject_o;
  logic [7:0]  rd_data_o;
  logic [15:0] status_o;
  logic        allow_read_o, allow_modify_o, allow_secure_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   seen_q = 1'b0;
  bit   done_flag = 1'b0;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  flash_status_tracker #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC),
    .WRSR_CYC (WRSR_CYC)
  ) u_dut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .cmd_wdata_i    (cmd_wdata_i),
    .accept_o       (accept_o),
    .reject_o       (reject_o),
    .rd_data_o      (rd_data_o),
    .status_o       (status_o),
    .allow_read_o   (allow_read_o),
    .allow_modify_o (allow_modify_o),
    .allow_secure_o (allow_secure_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) seen_q <= cmd_valid_i;

  // monitor: pops the expected response of the command captured at the last edge
  always @(negedge clk_i) begin
    if (seen_q) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R12: response without expectation, actual %0b expected none", accept_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " accept"}, {31'd0, accept_o}, {31'd0, e.acc});
        chk({e.tag, " R12 reject"}, {31'd0, reject_o}, {31'd0, !e.acc});
        if (e.chk_rd) chk({e.tag, " rd_data"}, {24'd0, rd_data_o}, {24'd0, e.rd});
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [15:0] d, input bit acc,
                      input bit chk_rd, input logic [7:0] rd, input string tag);
    exp_q.push_back('{acc: acc, chk_rd: chk_rd, rd: rd, tag: tag});
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input bit acc, input string tag);
    send(op, 16'h0000, acc, 1'b0, 8'h00, tag);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (status_o[0] && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && status_o[0]; i++) @(negedge clk_i);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 status", {16'd0, status_o}, 32'h0);
    chk("R1 accept", {31'd0, accept_o}, 32'h0);
    chk("R1 reject", {31'd0, reject_o}, 32'h0);
    chk("R1 allow_read", {31'd0, allow_read_o}, 32'h1);

    cmd(8'h02, 1'b0, "R4 program without wel");
    chk("R4 no state change", {16'd0, status_o}, 32'h0);
    cmd(8'h06, 1'b1, "R2 wren");
    chk("R2 wel set", {31'd0, status_o[1]}, 32'h1);
    chk("R4 allow_modify", {31'd0, allow_modify_o}, 32'h1);
    cmd(8'h04, 1'b1, "R2 wrdi");
    chk("R2 wel clear", {31'd0, status_o[1]}, 32'h0);
    cmd(8'h20, 1'b0, "R4 erase without wel");

    // status write, then traffic while busy
    cmd(8'h06, 1'b1, "R2 wren");
    send(8'h01, 16'h4058, 1'b1, 1'b0, 8'h00, "R10 status write");
    cmd(8'h06, 1'b0, "R6 wren while busy");
    send(8'h05, 16'h0, 1'b1, 1'b1, 8'h5B, "R3 low read while busy");
    cmd(8'h75, 1'b0, "R7 suspend during status write");
    wait_idle();
    chk("R5 low byte after status write", {24'd0, status_o[7:0]}, 32'h58);
    send(8'h35, 16'h0, 1'b1, 1'b1, 8'h40, "R3 high read");

    cmd(8'h06, 1'b1, "R2 wren");
    cmd(8'h02, 1'b1, "R5 program");
    count_busy(n);
    chk("R5 program length", n, PROG_CYC);
    chk("R5 wel cleared", {31'd0, status_o[1]}, 32'h0);

    cmd(8'h06, 1'b1, "R2 wren");
    cmd(8'hC7, 1'b1, "R5 chip erase");
    count_busy(n);
    chk("R5 chip erase length", n, CHIP_CYC);

    // suspend partway through a sector erase
    cmd(8'h06, 1'b1, "R2 wren");
    cmd(8'h20, 1'b1, "R5 sector erase");
    repeat (3) @(negedge clk_i);
    cmd(8'h75, 1'b1, "R7 suspend");
    chk("R7 sus set", {31'd0, status_o[15]}, 32'h1);
    chk("R7 busy reads 0", {31'd0, status_o[0]}, 32'h0);
    cmd(8'h03, 1'b1, "R8 read while suspended");
    cmd(8'h02, 1'b0, "R8 program while suspended");
    cmd(8'h01, 1'b0, "R8 status write while suspended");
    cmd(8'h44, 1'b0, "R8 security erase while suspended");
    cmd(8'hD8, 1'b0, "R8 block erase while suspended");
    cmd(8'h04, 1'b1, "R8 wrdi while suspended");
    cmd(8'h06, 1'b1, "R8 wren while suspended");
    chk("R8 allow_modify low", {31'd0, allow_modify_o}, 32'h0);
    send(8'h05, 16'h0, 1'b1, 1'b1, 8'h5A, "R3 low read while suspended");
    send(8'h35, 16'h0, 1'b1, 1'b1, 8'hC0, "R3 high read while suspended");
    repeat (10) @(negedge clk_i);
    chk("R7 still held", {30'd0, status_o[15], status_o[0]}, 32'h2);
    cmd(8'h7A, 1'b1, "R9 resume");
    count_busy(n);
    chk("R9 remaining length", n, SECT_CYC - 3);
    chk("R9 sus clear", {31'd0, status_o[15]}, 32'h0);
    chk("R5 wel cleared after resume", {31'd0, status_o[1]}, 32'h0);
    cmd(8'h7A, 1'b0, "R9 resume when not suspended");
    cmd(8'h75, 1'b0, "R7 suspend when idle");
    chk("R7 sus stays 0", {31'd0, status_o[15]}, 32'h0);

    // security lock
    cmd(8'h06, 1'b1, "R2 wren");
    cmd(8'h44, 1'b1, "R11 security erase unlocked");
    wait_idle();
    cmd(8'h06, 1'b1, "R2 wren");
    send(8'h01, 16'h0400, 1'b1, 1'b0, 8'h00, "R10 set lock");
    wait_idle();
    send(8'h35, 16'h0, 1'b1, 1'b1, 8'h04, "R10 lock read");
    cmd(8'h06, 1'b1, "R2 wren");
    chk("R11 allow_secure low", {31'd0, allow_secure_o}, 32'h0);
    cmd(8'h42, 1'b0, "R11 security program locked");
    cmd(8'h44, 1'b0, "R11 security erase locked");
    chk("R11 wel untouched", {31'd0, status_o[1]}, 32'h1);
    send(8'h01, 16'h0000, 1'b1, 1'b0, 8'h00, "R10 write zero lock");
    wait_idle();
    send(8'h35, 16'h0, 1'b1, 1'b1, 8'h04, "R10 lock sticky");

    cmd(8'hFF, 1'b0, "R12 unknown opcode");
    send(8'h05, 16'h0, 1'b1, 1'b1, 8'h00, "R3 final low read");
    @(negedge clk_i);
    chk("R12 quiet accept", {31'd0, accept_o}, 32'h0);
    chk("R12 quiet reject", {31'd0, reject_o}, 32'h0);
    chk("R12 queue drained", exp_q.size(), 0);
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk_i);
      if (done_flag) break;
    end
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule